// File: doc/BRIEF.md
# Shared-Server Request Hub with Response Steering

This block lets several independent clients share one server. Each client offers requests through its own valid/ready port. The hub merges them into one stream toward the server. Every request carries the index of the client that issued it, so the server always knows who is asking.

On the return side, the server issues a response together with a client index. The hub removes the index and places the payload in a small per-client response buffer. Each client drains its own buffer through a private valid/ready channel. A response whose destination buffer is full holds the server's response port until space opens. A response whose index names no client is absorbed, discarded and recorded in a sticky error flag.

Clients take turns on the request path in rotating order. Responses to any one client come out in the order the server issued them.

Top module: `hub_server`

## Requirements
- R1: When a request is transferred to the server (`srvReqValid` and `srvReqReady` both high), `srvReqId` equals the index of the client whose `clientReqReady` bit is high, and `srvReqData` equals that client's request payload.
- R2: In any cycle at most one bit of `clientReqReady` is high. A bit is high only if that client's request is valid and `srvReqReady` is high.
- R3: Arbitration is round-robin. After client i transfers a request, the search for the next grant starts at client i+1 and wraps from NUM_CLIENTS-1 to 0. After reset the search starts at client 0.
- R4: A response accepted with ID k below NUM_CLIENTS is presented to client k alone on `clientRespValid[k]` / `clientRespData` slice k, from the following cycle. The payload is carried without the ID.
- R5: Responses to one client leave its buffer in the order the server issued them.
- R6: `srvRespReady` is low exactly when the response ID is in range and that client's buffer already holds RESP_DEPTH entries. The response is then held, not lost.
- R7: A response with an ID of NUM_CLIENTS or more is accepted (`srvRespReady` high), reaches no client, and sets `badIdFlag` from the next cycle. The flag stays high until reset.
- R8: After reset, `srvReqValid`, every `clientRespValid` bit and `badIdFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clientReqValid | input | NUM_CLIENTS | Per-client request valid |
| clientReqData | input | NUM_CLIENTS*DATA_W | Per-client request payloads, client i at bits i*DATA_W upward |
| clientReqReady | output | NUM_CLIENTS | Per-client request accepted |
| srvReqValid | output | 1 | Merged request valid toward the server |
| srvReqId | output | ID_W | Index of the client owning the merged request |
| srvReqData | output | DATA_W | Merged request payload |
| srvReqReady | input | 1 | Server takes the merged request |
| srvRespValid | input | 1 | Server response valid |
| srvRespId | input | ID_W | Destination client index of the response |
| srvRespData | input | DATA_W | Response payload |
| srvRespReady | output | 1 | Hub takes the response |
| clientRespValid | output | NUM_CLIENTS | Per-client buffered response valid |
| clientRespData | output | NUM_CLIENTS*DATA_W | Per-client response payloads, client i at bits i*DATA_W upward |
| clientRespReady | input | NUM_CLIENTS | Per-client response taken |
| badIdFlag | output | 1 | Sticky flag: an out-of-range response ID was seen |

## Verification
The bound checker watches the following properties on every cycle:
- the request grant is single and tied to a valid request;
- the ID handed to the server names the granted client;
- a held response always points at a full, non-empty buffer;
- an accepted in-range response shows up as valid at its destination on the next cycle;
- the error flag rises after a bad ID and never falls.

The bench scenarios cover what a cycle-local property cannot:
- the exact rotating grant sequence under several request patterns;
- payload integrity and per-client ordering through the buffers, checked by a scoreboard;
- the stall-and-release sequence on a full buffer;
- the absence of any delivery for a discarded response.

// File: rtl/hub_pkg.sv
package hub_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic reqFire;   // merged request transferred this cycle
    logic respPush;  // response written into its client buffer
    logic respDrop;  // response carried an unknown ID and is discarded
  } hubStrobes_t;
endpackage

// File: rtl/hub_ctrl.sv
module hub_ctrl
  import hub_pkg::*;
#(
  parameter int NUM_CLIENTS = 4,
  parameter int ID_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CLIENTS-1:0] clientReqValid,
  input  logic                   srvReqReady,
  input  logic                   srvRespValid,
  input  logic [ID_W-1:0]        srvRespId,
  input  logic [NUM_CLIENTS-1:0] respFull,
  output hubStrobes_t            strobes,
  output logic [ID_W-1:0]        grantIdx,
  output logic [NUM_CLIENTS-1:0] grantVec,
  output logic                   anyReq,
  output logic                   srvRespReady
);
  logic [ID_W-1:0]        rrPtr;
  logic [NUM_CLIENTS-1:0] fullShift;
  logic                   idInRange;

  // rotating priority search starting at rrPtr
  always_comb begin
    int idx;
    grantIdx = '0;
    grantVec = '0;
    anyReq   = 1'b0;
    for (int k = 0; k < NUM_CLIENTS; k++) begin
      idx = (int'(rrPtr) + k) % NUM_CLIENTS;
      if (!anyReq && clientReqValid[idx]) begin
        anyReq        = 1'b1;
        grantIdx      = ID_W'(idx);
        grantVec[idx] = 1'b1;
      end
    end
  end

  assign idInRange    = srvRespId < ID_W'(NUM_CLIENTS);
  assign fullShift    = respFull >> srvRespId;
  assign srvRespReady = !(idInRange && fullShift[0]);

  always_comb begin
    strobes.reqFire  = anyReq && srvReqReady;
    strobes.respPush = srvRespValid && idInRange && !fullShift[0];
    strobes.respDrop = srvRespValid && !idInRange;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobes.reqFire) begin
      rrPtr <= (grantIdx == ID_W'(NUM_CLIENTS - 1)) ? '0 : grantIdx + 1'b1;
    end
  end
endmodule

// File: rtl/hub_dp.sv
module hub_dp
  import hub_pkg::*;
#(
  parameter int NUM_CLIENTS = 4,
  parameter int DATA_W = 16,
  parameter int RESP_DEPTH = 2,
  parameter int ID_W = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  hubStrobes_t                   strobes,
  input  logic [ID_W-1:0]               grantIdx,
  input  logic [NUM_CLIENTS*DATA_W-1:0] clientReqData,
  input  logic [ID_W-1:0]               srvRespId,
  input  logic [DATA_W-1:0]             srvRespData,
  input  logic [NUM_CLIENTS-1:0]        clientRespReady,
  output logic [DATA_W-1:0]             srvReqData,
  output logic [NUM_CLIENTS-1:0]        respFull,
  output logic [NUM_CLIENTS-1:0]        clientRespValid,
  output logic [NUM_CLIENTS*DATA_W-1:0] clientRespData,
  output logic                          badIdFlag
);
  localparam int AW = (RESP_DEPTH > 1) ? $clog2(RESP_DEPTH) : 1;
  localparam int CW = $clog2(RESP_DEPTH + 1);

  // request payload mux
  always_comb begin
    srvReqData = '0;
    for (int i = 0; i < NUM_CLIENTS; i++) begin
      if (grantIdx == ID_W'(i)) srvReqData = clientReqData[i*DATA_W +: DATA_W];
    end
  end

  // one response buffer per client
  for (genvar g = 0; g < NUM_CLIENTS; g++) begin : gBuf
    logic [DATA_W-1:0] mem [RESP_DEPTH];
    logic [AW-1:0]     wrPtr, rdPtr;
    logic [CW-1:0]     cnt;
    logic              push, pop;

    assign push               = strobes.respPush && (srvRespId == ID_W'(g));
    assign pop                = clientRespValid[g] && clientRespReady[g];
    assign respFull[g]        = cnt == CW'(RESP_DEPTH);
    assign clientRespValid[g] = cnt != '0;
    assign clientRespData[g*DATA_W +: DATA_W] = mem[rdPtr];

    always_ff @(posedge clk) begin
      if (push) mem[wrPtr] <= srvRespData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        cnt   <= '0;
      end else begin
        if (push) wrPtr <= (wrPtr == AW'(RESP_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        if (pop)  rdPtr <= (rdPtr == AW'(RESP_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        if (push && !pop)      cnt <= cnt + 1'b1;
        else if (pop && !push) cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 badIdFlag <= 1'b0;
    else if (strobes.respDrop) badIdFlag <= 1'b1;
  end
endmodule

// File: rtl/hub_server.sv
module hub_server
  import hub_pkg::*;
#(
  parameter int NUM_CLIENTS = 4,
  parameter int DATA_W = 16,
  parameter int RESP_DEPTH = 2,
  localparam int ID_W = $clog2(NUM_CLIENTS) + 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CLIENTS-1:0]        clientReqValid,
  input  logic [NUM_CLIENTS*DATA_W-1:0] clientReqData,
  output logic [NUM_CLIENTS-1:0]        clientReqReady,
  output logic                          srvReqValid,
  output logic [ID_W-1:0]               srvReqId,
  output logic [DATA_W-1:0]             srvReqData,
  input  logic                          srvReqReady,
  input  logic                          srvRespValid,
  input  logic [ID_W-1:0]               srvRespId,
  input  logic [DATA_W-1:0]             srvRespData,
  output logic                          srvRespReady,
  output logic [NUM_CLIENTS-1:0]        clientRespValid,
  output logic [NUM_CLIENTS*DATA_W-1:0] clientRespData,
  input  logic [NUM_CLIENTS-1:0]        clientRespReady,
  output logic                          badIdFlag
);
  hubStrobes_t            strobes;
  logic [ID_W-1:0]        grantIdx;
  logic [NUM_CLIENTS-1:0] grantVec;
  logic [NUM_CLIENTS-1:0] respFull;
  logic                   anyReq;

  hub_ctrl #(.NUM_CLIENTS(NUM_CLIENTS), .ID_W(ID_W)) uCtrl (
    .clk(clk), .rstN(rstN), .clientReqValid(clientReqValid), .srvReqReady(srvReqReady),
    .srvRespValid(srvRespValid), .srvRespId(srvRespId), .respFull(respFull),
    .strobes(strobes), .grantIdx(grantIdx), .grantVec(grantVec), .anyReq(anyReq),
    .srvRespReady(srvRespReady)
  );

  hub_dp #(.NUM_CLIENTS(NUM_CLIENTS), .DATA_W(DATA_W), .RESP_DEPTH(RESP_DEPTH), .ID_W(ID_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .grantIdx(grantIdx),
    .clientReqData(clientReqData), .srvRespId(srvRespId), .srvRespData(srvRespData),
    .clientRespReady(clientRespReady), .srvReqData(srvReqData), .respFull(respFull),
    .clientRespValid(clientRespValid), .clientRespData(clientRespData), .badIdFlag(badIdFlag)
  );

  assign srvReqValid    = anyReq;
  assign srvReqId       = grantIdx;
  assign clientReqReady = grantVec & {NUM_CLIENTS{srvReqReady}};
endmodule

// File: rtl/hub_server_checker.sv
module hub_server_checker #(
  parameter int NUM_CLIENTS = 4,
  parameter int DATA_W = 16,
  parameter int RESP_DEPTH = 2,
  localparam int ID_W = $clog2(NUM_CLIENTS) + 1
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_CLIENTS-1:0]        clientReqValid,
  input logic [NUM_CLIENTS*DATA_W-1:0] clientReqData,
  input logic [NUM_CLIENTS-1:0]        clientReqReady,
  input logic                          srvReqValid,
  input logic [ID_W-1:0]               srvReqId,
  input logic [DATA_W-1:0]             srvReqData,
  input logic                          srvReqReady,
  input logic                          srvRespValid,
  input logic [ID_W-1:0]               srvRespId,
  input logic [DATA_W-1:0]             srvRespData,
  input logic                          srvRespReady,
  input logic [NUM_CLIENTS-1:0]        clientRespValid,
  input logic [NUM_CLIENTS*DATA_W-1:0] clientRespData,
  input logic [NUM_CLIENTS-1:0]        clientRespReady,
  input logic                          badIdFlag
);
  logic [NUM_CLIENTS-1:0] rdyShift, vldShift;
  logic                   respIdOk;
  logic [ID_W-1:0]        lastRespId;

  assign rdyShift = clientReqReady >> srvReqId;
  assign vldShift = clientRespValid >> srvRespId;
  assign respIdOk = srvRespId < ID_W'(NUM_CLIENTS);

  always_ff @(posedge clk) lastRespId <= srvRespId;

  a_r1_id_names_granted: assert property (@(posedge clk) disable iff (!rstN)
    srvReqValid && srvReqReady |-> rdyShift[0] && (srvReqId < ID_W'(NUM_CLIENTS)));

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clientReqReady));

  a_r2_grant_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    (clientReqReady & ~clientReqValid) == '0);

  a_r4_push_visible: assert property (@(posedge clk) disable iff (!rstN)
    srvRespValid && srvRespReady && respIdOk
      |=> ((clientRespValid >> lastRespId) & NUM_CLIENTS'(1)) != '0);

  a_r6_stall_only_on_full: assert property (@(posedge clk) disable iff (!rstN)
    srvRespValid && !srvRespReady |-> respIdOk && vldShift[0]);

  a_r7_bad_id_flags: assert property (@(posedge clk) disable iff (!rstN)
    srvRespValid && !respIdOk |-> srvRespReady ##1 badIdFlag);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    badIdFlag |=> badIdFlag);
endmodule

bind hub_server hub_server_checker #(
  .NUM_CLIENTS(NUM_CLIENTS), .DATA_W(DATA_W), .RESP_DEPTH(RESP_DEPTH)
) uChk (.*);

// File: tb/hub_server_test.sv
`timescale 1ns/1ps
module hub_server_test;
  localparam int N = 4;
  localparam int DW = 16;
  localparam int IW = $clog2(N) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0]    clientReqValid = '0;
  logic [N*DW-1:0] clientReqData = '0;
  logic [N-1:0]    clientReqReady;
  logic            srvReqValid;
  logic [IW-1:0]   srvReqId;
  logic [DW-1:0]   srvReqData;
  logic            srvReqReady = 1'b0;
  logic            srvRespValid = 1'b0;
  logic [IW-1:0]   srvRespId = '0;
  logic [DW-1:0]   srvRespData = '0;
  logic            srvRespReady;
  logic [N-1:0]    clientRespValid;
  logic [N*DW-1:0] clientRespData;
  logic [N-1:0]    clientRespReady = '1;
  logic            badIdFlag;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  logic [DW-1:0] expMem [N][16];
  int head [N];
  int tail [N];

  always #2.5 clk = ~clk;

  hub_server #(.NUM_CLIENTS(N), .DATA_W(DW), .RESP_DEPTH(2)) uut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  // scoreboard monitor: R4, R5
  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < N; c++) begin
        if (clientRespValid[c] && clientRespReady[c]) begin
          if (head[c] == tail[c]) begin
            check(1'b0, "R4 unexpected delivery", 32'(c), 32'hffff);
          end else begin
            check(clientRespData[c*DW +: DW] == expMem[c][head[c] % 16], "R4/R5 payload",
                  32'(clientRespData[c*DW +: DW]), 32'(expMem[c][head[c] % 16]));
            head[c]++;
          end
        end
      end
    end
  end

  // driver: one response, waits for acceptance, records expectation
  task automatic sendResp(input int id, input logic [DW-1:0] data);
    @(posedge clk); #1;
    srvRespValid = 1'b1;
    srvRespId = IW'(id);
    srvRespData = data;
    @(negedge clk);
    while (!srvRespReady) @(negedge clk);
    if (id < N) begin
      expMem[id][tail[id] % 16] = data;
      tail[id]++;
    end
    @(posedge clk); #1;
    srvRespValid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    for (int c = 0; c < N; c++) begin
      head[c] = 0;
      tail[c] = 0;
      clientReqData[c*DW +: DW] = DW'(16'h100 + c);
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(srvReqValid == 1'b0, "R8 srvReqValid", 32'(srvReqValid), 32'd0);
    check(clientRespValid == '0, "R8 clientRespValid", 32'(clientRespValid), 32'd0);
    check(badIdFlag == 1'b0, "R8 badIdFlag", 32'(badIdFlag), 32'd0);

    // R3 all clients: expect 0,1,2,3
    @(posedge clk); #1;
    clientReqValid = '1;
    srvReqReady = 1'b1;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      check(srvReqId == IW'(k), "R3 grant order", 32'(srvReqId), 32'(k));
      check(srvReqData == DW'(16'h100 + k), "R1 payload", 32'(srvReqData), 32'(16'h100 + k));
      check(clientReqReady == N'(1 << k), "R2 ready vector", 32'(clientReqReady), 32'(1 << k));
      @(posedge clk); #1;
      clientReqValid[k] = 1'b0;
    end

    // R3 sparse: clients 1 and 3 held, expect 1,3,1
    clientReqValid = 4'b1010;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(srvReqId == IW'((k % 2 == 0) ? 1 : 3), "R3 sparse rotation", 32'(srvReqId),
            32'((k % 2 == 0) ? 1 : 3));
      check(srvReqData == DW'(16'h100 + ((k % 2 == 0) ? 1 : 3)), "R1 sparse payload",
            32'(srvReqData), 32'(16'h100 + ((k % 2 == 0) ? 1 : 3)));
    end
    // after granting 1 the search starts at 2 -> 3 wins even with 0 requesting
    @(posedge clk); #1;
    clientReqValid = 4'b1001;
    srvReqReady = 1'b0;
    @(negedge clk);
    check(srvReqValid == 1'b1 && clientReqReady == '0, "R2 no ready when server busy",
          32'(clientReqReady), 32'd0);
    check(srvReqId == IW'(3), "R3 pointer after 1", 32'(srvReqId), 32'd3);
    @(posedge clk); #1;
    clientReqValid = '0;

    // R4 routing with all clients ready
    sendResp(2, 16'hA002);
    sendResp(0, 16'hA000);
    sendResp(3, 16'hA003);
    sendResp(1, 16'hA001);
    sendResp(2, 16'hB002);
    repeat (3) @(negedge clk);

    // R5, R6: stall client 1
    clientRespReady[1] = 1'b0;
    sendResp(1, 16'hC001);
    sendResp(1, 16'hC002);
    @(posedge clk); #1;
    srvRespValid = 1'b1;
    srvRespId = IW'(1);
    srvRespData = 16'hC003;
    repeat (3) begin
      @(negedge clk);
      check(srvRespReady == 1'b0, "R6 stall on full buffer", 32'(srvRespReady), 32'd0);
    end
    check(clientRespValid == 4'b0010, "R4 only client 1 holds data", 32'(clientRespValid), 32'h2);
    @(posedge clk); #1;
    srvRespValid = 1'b0;
    clientRespReady[1] = 1'b1;
    sendResp(1, 16'hC003);
    repeat (4) @(negedge clk);

    // R7 bad id
    @(posedge clk); #1;
    srvRespValid = 1'b1;
    srvRespId = IW'(5);
    srvRespData = 16'hDEAD;
    @(negedge clk);
    check(srvRespReady == 1'b1, "R7 bad id accepted", 32'(srvRespReady), 32'd1);
    @(posedge clk); #1;
    srvRespValid = 1'b0;
    @(negedge clk);
    check(badIdFlag == 1'b1, "R7 flag set", 32'(badIdFlag), 32'd1);
    check(clientRespValid == '0, "R7 nothing delivered", 32'(clientRespValid), 32'd0);
    sendResp(0, 16'hE000);
    repeat (3) @(negedge clk);
    check(badIdFlag == 1'b1, "R7 flag sticky", 32'(badIdFlag), 32'd1);

    for (int c = 0; c < N; c++) begin
      check(head[c] == tail[c], "R4 all responses delivered", 32'(head[c]), 32'(tail[c]));
    end
    finishRun();
  end
endmodule